// File: doc/BRIEF.md
# Per-Channel Stimulus Output Conditioner

This block sits in front of the output pins of a digital stimulus generator. Each of its channels picks one of four sources: a fixed low, a fixed high, the bit supplied by the pattern sequencer, or a square wave locked to the generator clock. The polarity of the square wave is set per channel. Mode, polarity and shift settings arrive on configuration buses with one field per channel. They are sampled on the rising clock edge together with the pattern word.

Any subset of channels can also be moved half a clock period later than the rest. A moved static or pattern channel is re-captured on the falling edge. A moved toggle channel has its waveform inverted. At a 250 MHz clock this places edges on a 2 ns grid instead of a 4 ns grid. All flops reset asynchronously.

Top module: `stim_out_cond`

## Requirements
- R1: While reset is asserted every pin is low, and every channel's configuration is cleared to mode 00 with no shift.
- R2: A channel whose 2-bit mode field (bits 2c+1:2c of the mode bus for channel c) holds 00 drives low, and one that holds 01 drives high, from the rising edge that sampled that mode.
- R3: Mode 10 drives the channel's pattern bit as sampled on a rising edge, valid from just after that edge.
- R4: Mode 11 without shift produces a clock-locked square wave: the pin equals the channel's polarity bit while the clock is low and its inverse while the clock is high.
- R5: With the channel's shift bit set, a low, high or pattern channel changes at the falling edge after the rising edge that sampled it, half a period after an unshifted channel with the same settings.
- R6: With the shift bit set, a toggle channel is half a period behind: the pin equals the inverse of the polarity bit while the clock is low and the polarity bit while the clock is high.
- R7: Changes on the pattern and configuration inputs between rising edges do not reach the pins, so channels whose settings did not change hold steady while other channels are reconfigured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator clock; also the toggle source |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_i | input | NCH | Pattern word from the sequencer |
| mode_i | input | 2*NCH | Per-channel source select, two bits per channel |
| tpol_i | input | NCH | Per-channel toggle polarity |
| hshift_i | input | NCH | Per-channel half-period shift enable |
| pin_o | output | NCH | Conditioned channel outputs |

## Verification
A wrong captured level or a stuck configuration bit shows on the affected pin within the first clock-high phase after the vector that exposes it. A fault in the falling-edge register shows half a cycle later, during the clock-low phase. A wrong polarity or shift term on a toggle channel inverts its waveform in both phases at once. Input leakage between edges shows when the pins are sampled just after the inputs move and before the next rising edge.

// File: rtl/stim_cond_pkg.sv
package stim_cond_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        SRC_LOW  = 2'b00,
        SRC_HIGH = 2'b01,
        SRC_PAT  = 2'b10,
        SRC_TOG  = 2'b11
    } src_e;

endpackage

// File: rtl/stim_src_sel.sv
module stim_src_sel
    import stim_cond_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              pat_i,
    output logic              lvl_o,
    output logic              tog_o
);

    // static level for the registered path; toggle channels park at 0
    always_comb begin
        lvl_o = 1'b0;
        tog_o = 1'b0;
        case (src_e'(mode_i))
            SRC_LOW:  lvl_o = 1'b0;
            SRC_HIGH: lvl_o = 1'b1;
            SRC_PAT:  lvl_o = pat_i;
            SRC_TOG:  tog_o = 1'b1;
            default:  lvl_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/stim_half_shift.sv
module stim_half_shift #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] late_d, late_q;

    always_comb begin
        late_d = d_i;
    end

    // falling-edge capture gives the half-period lag
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) late_q <= '0;
        else        late_q <= late_d;
    end

    assign q_o = late_q;

endmodule

// File: rtl/stim_pin_mux.sv
module stim_pin_mux (
    input  logic clk_i,
    input  logic lvl_i,
    input  logic late_i,
    input  logic tog_i,
    input  logic pol_i,
    input  logic shf_i,
    output logic pin_o
);

    always_comb begin
        if (tog_i)      pin_o = pol_i ^ clk_i ^ shf_i;
        else if (shf_i) pin_o = late_i;
        else            pin_o = lvl_i;
    end

endmodule

// File: rtl/stim_out_cond.sv
module stim_out_cond
    import stim_cond_pkg::*;
#(
    parameter int NCH = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      pat_i,
    input  logic [2*NCH-1:0]    mode_i,
    input  logic [NCH-1:0]      tpol_i,
    input  logic [NCH-1:0]      hshift_i,
    output logic [NCH-1:0]      pin_o
);

    typedef struct packed {
        logic [NCH-1:0] lvl;
        logic [NCH-1:0] tog;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] shf;
    } chan_st_t;

    chan_st_t       st_d, st_q;
    logic [NCH-1:0] lvl_c, tog_c, late_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_sel
        stim_src_sel u_sel (
            .mode_i (mode_i[ch*MODE_W +: MODE_W]),
            .pat_i  (pat_i[ch]),
            .lvl_o  (lvl_c[ch]),
            .tog_o  (tog_c[ch])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_c;
        st_d.tog = tog_c;
        st_d.pol = tpol_i;
        st_d.shf = hshift_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    stim_half_shift #(.W(NCH)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (st_q.lvl),
        .q_o   (late_q)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_mux
        stim_pin_mux u_mux (
            .clk_i  (clk),
            .lvl_i  (st_q.lvl[ch]),
            .late_i (late_q[ch]),
            .tog_i  (st_q.tog[ch]),
            .pol_i  (st_q.pol[ch]),
            .shf_i  (st_q.shf[ch]),
            .pin_o  (pin_o[ch])
        );
    end

endmodule

// File: rtl/stim_out_cond_chk.sv
module stim_out_cond_chk #(
    parameter int NCH = 30
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      pat_i,
    input logic [2*NCH-1:0]    mode_i,
    input logic [NCH-1:0]      tpol_i,
    input logic [NCH-1:0]      hshift_i,
    input logic [NCH-1:0]      pin_o
);

    logic [NCH-1:0]   c_pat, c_pol, c_shf, c2_pat;
    logic [2*NCH-1:0] c_mode, c2_mode;
    logic [NCH-1:0]   m_static, m_pat, m_tog, now_lvl, old_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_pat <= '0; c_pol <= '0; c_shf <= '0; c_mode <= '0;
            c2_pat <= '0; c2_mode <= '0;
        end else begin
            c_pat <= pat_i; c_pol <= tpol_i; c_shf <= hshift_i; c_mode <= mode_i;
            c2_pat <= c_pat; c2_mode <= c_mode;
        end
    end

    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            m_static[ch] = (c_mode[2*ch+1] == 1'b0);
            m_pat[ch]    = (c_mode[2*ch +: 2] == 2'b10);
            m_tog[ch]    = (c_mode[2*ch +: 2] == 2'b11);
            now_lvl[ch]  = (c_mode[2*ch +: 2] == 2'b01) |
                           ((c_mode[2*ch +: 2] == 2'b10) & c_pat[ch]);
            old_lvl[ch]  = (c2_mode[2*ch +: 2] == 2'b01) |
                           ((c2_mode[2*ch +: 2] == 2'b10) & c2_pat[ch]);
        end
    end

    always @(negedge clk) begin
        if (!rst_n) assert_reset_low_R1: assert (pin_o == '0);
    end

    assert_fixed_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ now_lvl) & m_static) == '0);

    assert_pattern_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ now_lvl) & m_pat) == '0);

    assert_toggle_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ c_pol) & m_tog & ~c_shf) == '0);

    assert_shift_lag_R5: assert property (@(negedge clk) disable iff (!rst_n)
        ((pin_o ^ old_lvl) & ~m_tog & c_shf) == '0);

    assert_toggle_shifted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o ^ ~c_pol) & m_tog & c_shf) == '0);

endmodule

bind stim_out_cond stim_out_cond_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pat_i    (pat_i),
    .mode_i   (mode_i),
    .tpol_i   (tpol_i),
    .hshift_i (hshift_i),
    .pin_o    (pin_o)
);

// File: tb/sim_stim_out_cond.sv
`timescale 1ns/100ps
module sim_stim_out_cond;

    localparam int NCH = 30;

    typedef struct {
        logic [NCH-1:0] early;
        logic [NCH-1:0] late;
        logic [NCH-1:0] m_fix;
        logic [NCH-1:0] m_pat;
        logic [NCH-1:0] m_tog;
        logic [NCH-1:0] m_dst;
        logic [NCH-1:0] m_dtg;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCH-1:0]     pat_i = '0;
    logic [2*NCH-1:0]   mode_i = '0;
    logic [NCH-1:0]     tpol_i = '0;
    logic [NCH-1:0]     hshift_i = '0;
    logic [NCH-1:0]     pin_o;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    logic [NCH-1:0] prev_lvl = '0;
    logic [31:0] lfsr = 32'h1BADC0DE;

    stim_out_cond #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .pat_i(pat_i), .mode_i(mode_i),
        .tpol_i(tpol_i), .hshift_i(hshift_i), .pin_o(pin_o)
    );

    always #2 clk = ~clk;

    task automatic cmp(input string tag, input logic [NCH-1:0] msk,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        if (msk != '0) begin
            n_chk++;
            if (((act ^ exp) & msk) != '0) begin
                n_bad++;
                $display("FAIL %s t=%0t actual=%h expected=%h mask=%h",
                         tag, $time, act & msk, exp & msk, msk);
            end
        end
    endtask

    // driver: drive in the clock-low phase, push the expected pin values
    task automatic apply(input logic [NCH-1:0] pat, input logic [2*NCH-1:0] mode,
                         input logic [NCH-1:0] pol, input logic [NCH-1:0] shf);
        exp_t e;
        @(negedge clk);
        #1.5;
        pat_i = pat; mode_i = mode; tpol_i = pol; hshift_i = shf;
        e.m_fix = '0; e.m_pat = '0; e.m_tog = '0; e.m_dst = '0; e.m_dtg = '0;
        for (int c = 0; c < NCH; c++) begin
            logic [1:0] m;
            logic v;
            m = mode[2*c +: 2];
            v = (m == 2'b01) | ((m == 2'b10) & pat[c]);
            if (m == 2'b11) begin
                e.early[c] = pol[c] ^ 1'b1 ^ shf[c];
                e.late[c]  = pol[c] ^ shf[c];
                if (shf[c]) e.m_dtg[c] = 1'b1; else e.m_tog[c] = 1'b1;
            end else begin
                e.early[c] = shf[c] ? prev_lvl[c] : v;
                e.late[c]  = v;
                if (shf[c])          e.m_dst[c] = 1'b1;
                else if (m == 2'b10) e.m_pat[c] = 1'b1;
                else                 e.m_fix[c] = 1'b1;
            end
            prev_lvl[c] = v;
        end
        q.push_back(e);
    endtask

    // monitor: clock-high phase, clock-low phase, then after inputs move
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q[0];
                cmp("R2 fixed level (clk high)", e.m_fix, pin_o, e.early);
                cmp("R3 pattern (clk high)", e.m_pat, pin_o, e.early);
                cmp("R4 toggle (clk high)", e.m_tog, pin_o, e.early);
                cmp("R5 shifted holds old (clk high)", e.m_dst, pin_o, e.early);
                cmp("R6 shifted toggle (clk high)", e.m_dtg, pin_o, e.early);
                #2;
                cmp("R2 fixed level (clk low)", e.m_fix, pin_o, e.late);
                cmp("R3 pattern (clk low)", e.m_pat, pin_o, e.late);
                cmp("R4 toggle (clk low)", e.m_tog, pin_o, e.late);
                cmp("R5 shifted updated (clk low)", e.m_dst, pin_o, e.late);
                cmp("R6 shifted toggle (clk low)", e.m_dtg, pin_o, e.late);
                #0.8;
                cmp("R7 inputs ignored between edges", {NCH{1'b1}}, pin_o, e.late);
                void'(q.pop_front());
            end
        end
    end

    function automatic logic [2*NCH-1:0] all_mode(input logic [1:0] m);
        logic [2*NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[2*c +: 2] = m;
        return r;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #300000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*NCH-1:0] mix;
        repeat (3) @(posedge clk);
        #1;
        cmp("R1 reset pins low (clk high)", {NCH{1'b1}}, pin_o, '0);
        #2;
        cmp("R1 reset pins low (clk low)", {NCH{1'b1}}, pin_o, '0);
        @(negedge clk);
        #1.5;
        rst_n = 1'b1;

        // R2: all low then all high
        apply('1, all_mode(2'b00), '0, '0);
        apply('0, all_mode(2'b01), '0, '0);
        // R3: alternating pattern words
        apply(30'h2AAAAAAA, all_mode(2'b10), '0, '0);
        apply(30'h15555555, all_mode(2'b10), '0, '0);
        apply('1, all_mode(2'b10), '0, '0);
        // R4: toggle both polarities
        apply('0, all_mode(2'b11), '0, '0);
        apply('0, all_mode(2'b11), '1, '0);
        // R6: shifted toggles
        apply('0, all_mode(2'b11), 30'h0F0F0F0F, '1);
        // R5: shifted pattern channels lag half a cycle
        apply('0, all_mode(2'b10), '0, '1);
        apply('1, all_mode(2'b10), '0, '1);
        apply(30'h0000FFFF, all_mode(2'b10), '0, 30'h00FF00FF);
        apply(30'h3FFF0000, all_mode(2'b10), '0, 30'h00FF00FF);
        // R7: keep channel 0..9 fixed high while others reconfigure
        for (int c = 0; c < NCH; c++) mix[2*c +: 2] = (c < 10) ? 2'b01 : 2'b10;
        apply(30'h3FFFFC00, mix, '0, '0);
        for (int c = 10; c < NCH; c++) mix[2*c +: 2] = 2'b11;
        apply('0, mix, 30'h3FFFFC00, 30'h15555400);
        // mixed pseudo-random vectors
        for (int k = 0; k < 60; k++) begin
            logic [NCH-1:0] p, pol, sh;
            logic [2*NCH-1:0] md;
            lfsr = step(lfsr); p = lfsr[NCH-1:0];
            lfsr = step(lfsr); md[31:0] = lfsr;
            lfsr = step(lfsr); md[2*NCH-1:32] = lfsr[2*NCH-33:0];
            lfsr = step(lfsr); pol = lfsr[NCH-1:0];
            lfsr = step(lfsr); sh = lfsr[NCH-1:0] & {NCH{lfsr[31]}};
            apply(p, md, pol, sh);
        end
        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule